// File: doc/BRIEF.md
# Flash Program/Erase Controller

This block sequences erase and program operations on a small modelled flash array. Software drives it through a two-register port. The control register holds the program-enable bit, the two erase-select bits, the sector number and a start strobe. The status register shows the busy flag and three sticky error flags. Program data arrives on a separate write port that carries a byte address, up to 64 bits of data and an access size. A configuration input sets the parallelism that every program write must match.

Each write is checked three ways before it is accepted:

- programming must be enabled,
- the access size must match the configured parallelism,
- the access must stay inside one 16-byte row.

A write that fails any check is dropped and raises the matching flag. An accepted write ANDs its data into the array, so bits can only go from 1 to 0. Only an erase returns them to 1. If an erase start and an accepted write arrive in the same cycle, the erase runs first and the program follows straight after it, with busy held high throughout.

The array is 8 sectors of 16 bytes. It can be read one 64-bit doubleword at a time through a combinational read port.

Top module: `flashpe_ctrl`

## Requirements
- R1: After reset, busy and all three error flags read 0, the control register reads 0, and every array byte reads 8'hFF.
- R2: A control write (register address 0) with the mass bit (bit 2) and start (bit 8) set, and the sector bit (bit 1) clear, raises busy for exactly ERASE_CYC cycles while idle. The whole array reads all ones in the cycle busy falls.
- R3: A control write with the sector bit (bit 1) and start (bit 8) set, the mass bit clear, and the sector number in bits 6:4, erases only that sector to all ones. It holds busy for ERASE_CYC cycles and leaves the other sectors unchanged.
- R4: A start with both the mass bit and the sector bit set erases nothing and does not raise busy.
- R5: With program-enable (control bit 0) set, a write of 2^size bytes is accepted when it matches parallelism and stays in its row (size 0/1/2/3 = 1/2/4/8 bytes). The byte at the write address takes data bits 7:0, and higher addresses take the following bytes. Busy stays high for exactly PROG_CYC cycles, after which each stored byte equals old AND new.
- R6: A write whose size differs from the parallelism setting is dropped and sets the size error flag (status bit 2).
- R7: A write with (address mod 16) + 2^size > 16 is dropped and sets the alignment error flag (status bit 1).
- R8: A write while program-enable is clear is dropped and sets the sequence error flag (status bit 3).
- R9: Error flags stay set until a write to status (register address 1) with a 1 in the flag's bit. Writing 0 to a flag leaves it unchanged.
- R10: While busy (status bit 0), program writes and control writes are ignored. They raise no flag, change no array byte and leave the control register unchanged.
- R11: An erase start and an accepted write in the same cycle run the erase first and then the program. Busy stays high for ERASE_CYC+PROG_CYC cycles, and the programmed bytes end equal to the new data.
- R12: A dropped write never raises busy and never changes the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| wr_valid | input | 1 | Program write request |
| wr_addr | input | ADDR_W (7) | Byte address of the write |
| wr_data | input | 64 | Write data; the lowest byte goes to wr_addr |
| wr_size | input | 2 | Access size, 2^wr_size bytes |
| par_cfg | input | 2 | Configured parallelism, same encoding as wr_size |
| rd_addr | input | ADDR_W-3 (4) | Doubleword index for array reads |
| rd_data | output | 64 | Array doubleword (combinational) |
| busy_o | output | 1 | Operation in progress |

## Verification
Error flags and busy become visible one cycle after the clock edge that samples the write or the start command. The array changes on the same edge at which busy falls:

- PROG_CYC cycles after an accepted write,
- ERASE_CYC cycles after an erase start,
- ERASE_CYC+PROG_CYC cycles after a combined start.

The bench drives inputs just after rising edges and compares every output at the following falling edge against a behavioural model that updates on the same rising edge. Each comparison therefore lands in the cycle where the result is due. Directed checks count busy cycles to confirm the exact lengths.

// File: rtl/flashpe_pkg.sv
package flashpe_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_MASS = 2'd1,
        OP_SECT = 2'd2,
        OP_PROG = 2'd3
    } op_e;

    typedef struct packed {
        logic align;
        logic size;
        logic seq;
    } err_t;

    // control register bit positions
    localparam int CB_PGEN  = 0;
    localparam int CB_SECT  = 1;
    localparam int CB_MASS  = 2;
    localparam int CB_SNUM  = 4;
    localparam int CB_START = 8;

    // status register bit positions
    localparam int SB_BUSY  = 0;
    localparam int SB_ALIGN = 1;
    localparam int SB_SIZE  = 2;
    localparam int SB_SEQ   = 3;

    function automatic logic [3:0] size_to_bytes(input logic [1:0] sz);
        return 4'd1 << sz;
    endfunction

endpackage

// File: rtl/flashpe_wcheck.sv
module flashpe_wcheck #(
    parameter int ROW_BYTES = 16,
    parameter int ADDR_W    = 7
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_size,
    input  logic [1:0]        par_cfg,
    input  logic              pgm_en,
    output logic              bad_align,
    output logic              bad_size,
    output logic              bad_seq,
    output logic              ok
);
    import flashpe_pkg::*;

    localparam int ROW_W = $clog2(ROW_BYTES);

    logic [ROW_W-1:0] row_off;
    logic [3:0]       nbytes;
    logic             unused_hi;

    assign row_off   = wr_addr[ROW_W-1:0];
    assign unused_hi = ^wr_addr;
    assign nbytes    = size_to_bytes(wr_size);

    always_comb begin
        bad_seq   = !pgm_en;
        bad_size  = (wr_size != par_cfg);
        bad_align = (32'(row_off) + 32'(nbytes)) > 32'(ROW_BYTES);
        ok        = !(bad_seq || bad_size || bad_align);
    end

endmodule

// File: rtl/flashpe_array.sv
module flashpe_array #(
    parameter int SECTORS    = 8,
    parameter int SECT_BYTES = 16
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    do_mass,
    input  logic                                    do_sect,
    input  logic [$clog2(SECTORS)-1:0]              sect_idx,
    input  logic                                    do_prog,
    input  logic [$clog2(SECTORS*SECT_BYTES)-1:0]   prog_addr,
    input  logic [63:0]                             prog_data,
    input  logic [1:0]                              prog_size,
    input  logic [$clog2(SECTORS*SECT_BYTES)-4:0]   rd_addr,
    output logic [63:0]                             rd_data
);
    import flashpe_pkg::*;

    localparam int BYTES  = SECTORS * SECT_BYTES;
    localparam int ADDR_W = $clog2(BYTES);
    localparam int SECT_W = $clog2(SECTORS);

    logic [7:0] cell_w [BYTES];
    logic [3:0] nbytes;

    assign nbytes = size_to_bytes(prog_size);

    for (genvar b = 0; b < BYTES; b++) begin : g_cell
        logic [ADDR_W-1:0] rel;
        logic              hit;
        logic              wipe;
        logic [7:0]        new_byte;
        logic [7:0]        cell_q;

        assign rel      = ADDR_W'(b) - prog_addr;
        assign hit      = do_prog && (32'(rel) < 32'(nbytes));
        assign wipe     = do_mass || (do_sect && (sect_idx == SECT_W'(b / SECT_BYTES)));
        assign new_byte = prog_data[{rel[2:0], 3'b000} +: 8];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= 8'hFF;
            end else if (wipe) begin
                cell_q <= 8'hFF;
            end else if (hit) begin
                cell_q <= cell_q & new_byte;
            end
        end

        assign cell_w[b] = cell_q;
    end

    always_comb begin
        for (int k = 0; k < 8; k++) begin
            rd_data[8*k +: 8] = cell_w[{rd_addr, 3'(k)}];
        end
    end

endmodule

// File: rtl/flashpe_ctrl.sv
module flashpe_ctrl #(
    parameter int SECTORS    = 8,
    parameter int SECT_BYTES = 16,
    parameter int ROW_BYTES  = 16,
    parameter int PROG_CYC   = 4,
    parameter int ERASE_CYC  = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  reg_we,
    input  logic                                  reg_addr,
    input  logic [31:0]                           reg_wdata,
    output logic [31:0]                           reg_rdata,
    input  logic                                  wr_valid,
    input  logic [$clog2(SECTORS*SECT_BYTES)-1:0] wr_addr,
    input  logic [63:0]                           wr_data,
    input  logic [1:0]                            wr_size,
    input  logic [1:0]                            par_cfg,
    input  logic [$clog2(SECTORS*SECT_BYTES)-4:0] rd_addr,
    output logic [63:0]                           rd_data,
    output logic                                  busy_o
);
    import flashpe_pkg::*;

    localparam int BYTES  = SECTORS * SECT_BYTES;
    localparam int ADDR_W = $clog2(BYTES);
    localparam int SECT_W = $clog2(SECTORS);
    localparam int MAXC   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W  = $clog2(MAXC) + 1;
    localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYC - 1);

    typedef struct packed {
        logic              pgm_en;
        logic              sect_sel;
        logic              mass_sel;
        logic [SECT_W-1:0] snum;
        op_e               op;
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        err_t              err;
        logic              pend;
        logic [ADDR_W-1:0] paddr;
        logic [63:0]       pdata;
        logic [1:0]        psize;
    } st_t;

    localparam st_t RST_ST = '0;

    st_t  st_d, st_q;
    logic finish, ctrl_wr, stat_wr, start_cmd, erase_go, wr_take, prog_go;
    logic bad_align, bad_size, bad_seq, chk_ok;
    logic pgm_en_w, err_align_w, err_size_w, err_seq_w;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata;

    flashpe_wcheck #(
        .ROW_BYTES (ROW_BYTES),
        .ADDR_W    (ADDR_W)
    ) wcheck_i (
        .wr_addr   (wr_addr),
        .wr_size   (wr_size),
        .par_cfg   (par_cfg),
        .pgm_en    (st_q.pgm_en),
        .bad_align (bad_align),
        .bad_size  (bad_size),
        .bad_seq   (bad_seq),
        .ok        (chk_ok)
    );

    flashpe_array #(
        .SECTORS    (SECTORS),
        .SECT_BYTES (SECT_BYTES)
    ) array_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_mass   (finish && (st_q.op == OP_MASS)),
        .do_sect   (finish && (st_q.op == OP_SECT)),
        .sect_idx  (st_q.snum),
        .do_prog   (finish && (st_q.op == OP_PROG)),
        .prog_addr (st_q.paddr),
        .prog_data (st_q.pdata),
        .prog_size (st_q.psize),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    always_comb begin
        st_d      = st_q;
        finish    = st_q.busy && (st_q.cnt == '0);
        ctrl_wr   = reg_we && (reg_addr == 1'b0) && !st_q.busy;
        stat_wr   = reg_we && (reg_addr == 1'b1);
        start_cmd = ctrl_wr && reg_wdata[CB_START];
        erase_go  = start_cmd && (reg_wdata[CB_MASS] != reg_wdata[CB_SECT]);
        wr_take   = wr_valid && !st_q.busy;
        prog_go   = wr_take && chk_ok;

        // write-one-to-clear, then any new failure sets again
        if (stat_wr) begin
            if (reg_wdata[SB_ALIGN]) st_d.err.align = 1'b0;
            if (reg_wdata[SB_SIZE])  st_d.err.size  = 1'b0;
            if (reg_wdata[SB_SEQ])   st_d.err.seq   = 1'b0;
        end
        if (wr_take) begin
            st_d.err.align = st_d.err.align | bad_align;
            st_d.err.size  = st_d.err.size  | bad_size;
            st_d.err.seq   = st_d.err.seq   | bad_seq;
        end

        if (ctrl_wr) begin
            st_d.pgm_en   = reg_wdata[CB_PGEN];
            st_d.sect_sel = reg_wdata[CB_SECT];
            st_d.mass_sel = reg_wdata[CB_MASS];
            st_d.snum     = reg_wdata[CB_SNUM +: SECT_W];
        end

        if (st_q.busy) begin
            if (!finish) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end else if ((st_q.op != OP_PROG) && st_q.pend) begin
                st_d.op   = OP_PROG;
                st_d.pend = 1'b0;
                st_d.cnt  = PROG_LOAD;
            end else begin
                st_d.busy = 1'b0;
                st_d.op   = OP_IDLE;
            end
        end else if (erase_go) begin
            st_d.busy = 1'b1;
            st_d.op   = reg_wdata[CB_MASS] ? OP_MASS : OP_SECT;
            st_d.cnt  = ERASE_LOAD;
            if (prog_go) begin
                st_d.pend  = 1'b1;
                st_d.paddr = wr_addr;
                st_d.pdata = wr_data;
                st_d.psize = wr_size;
            end
        end else if (prog_go) begin
            st_d.busy  = 1'b1;
            st_d.op    = OP_PROG;
            st_d.cnt   = PROG_LOAD;
            st_d.paddr = wr_addr;
            st_d.pdata = wr_data;
            st_d.psize = wr_size;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == 1'b0) begin
            reg_rdata[CB_PGEN]            = st_q.pgm_en;
            reg_rdata[CB_SECT]            = st_q.sect_sel;
            reg_rdata[CB_MASS]            = st_q.mass_sel;
            reg_rdata[CB_SNUM +: SECT_W]  = st_q.snum;
        end else begin
            reg_rdata[SB_BUSY]  = st_q.busy;
            reg_rdata[SB_ALIGN] = st_q.err.align;
            reg_rdata[SB_SIZE]  = st_q.err.size;
            reg_rdata[SB_SEQ]   = st_q.err.seq;
        end
    end

    assign busy_o      = st_q.busy;
    assign pgm_en_w    = st_q.pgm_en;
    assign err_align_w = st_q.err.align;
    assign err_size_w  = st_q.err.size;
    assign err_seq_w   = st_q.err.seq;

endmodule

// File: rtl/flashpe_chk.sv
module flashpe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic       reg_addr,
    input logic       cmd_start,
    input logic       cmd_mass,
    input logic       cmd_sect,
    input logic       clr_seq,
    input logic       wr_valid,
    input logic [1:0] wr_size,
    input logic [1:0] par_cfg,
    input logic       busy,
    input logic       pgm_en,
    input logic       err_align,
    input logic       err_size,
    input logic       err_seq
);

    // R2 / R5: busy only rises after a command or a write
    a_r2_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we || wr_valid));

    // R4: conflicting erase select starts nothing
    a_r4_conflict_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_we && !reg_addr && cmd_start && cmd_mass && cmd_sect && !wr_valid)
        |=> !busy);

    // R6: size mismatch raises its flag
    a_r6_size_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_valid && (wr_size != par_cfg)) |=> err_size);

    // R8: write without program enable raises its flag
    a_r8_seq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_valid && !pgm_en) |=> err_seq);

    // R9: a set flag stays until cleared by a one
    a_r9_seq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_seq && !(reg_we && reg_addr && clr_seq)) |=> err_seq);

    // R10: writes during busy touch no flag
    a_r10_busy_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_valid && !reg_we) |=> $stable({err_align, err_size, err_seq}));

    // R12: a dropped write does not start an operation
    a_r12_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_valid && (wr_size != par_cfg) && !(reg_we && !reg_addr && cmd_start))
        |=> !busy);

endmodule

bind flashpe_ctrl flashpe_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .cmd_start (reg_wdata[8]),
    .cmd_mass  (reg_wdata[2]),
    .cmd_sect  (reg_wdata[1]),
    .clr_seq   (reg_wdata[3]),
    .wr_valid  (wr_valid),
    .wr_size   (wr_size),
    .par_cfg   (par_cfg),
    .busy      (busy_o),
    .pgm_en    (pgm_en_w),
    .err_align (err_align_w),
    .err_size  (err_size_w),
    .err_seq   (err_seq_w)
);

// File: tb/flashpe_ctrl_tb_top.sv
module flashpe_ctrl_tb_top;

    localparam int PROG  = 4;
    localparam int ERASE = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b1;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wr_valid = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [1:0]  wr_size = 2'd3;
    logic [1:0]  par_cfg = 2'd3;
    logic [3:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        busy_o;

    int    checks = 0;
    int    errors = 0;
    string phase = "R1";
    bit    scan_en = 1'b1;
    logic [3:0] dir_addr = '0;
    logic [3:0] scan_ptr = '0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    flashpe_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_size   (wr_size),
        .par_cfg   (par_cfg),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy_o    (busy_o)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0]  mm [128];
    int          m_left, m_op, m_snb, p_addr, p_n, nb;
    bit          m_pend, m_pg, m_ser, m_mer, e_al, e_sz, e_sq, wok, fa, fs, fq;
    logic [63:0] p_data;

    task automatic apply_op(input int op);
        if (op == 1) begin
            for (int i = 0; i < 128; i++) mm[i] = 8'hFF;
        end else if (op == 2) begin
            for (int i = 0; i < 16; i++) mm[m_snb*16 + i] = 8'hFF;
        end else if (op == 3) begin
            for (int i = 0; i < p_n; i++) mm[p_addr + i] = mm[p_addr + i] & p_data[8*i +: 8];
        end
    endtask

    task automatic load_prog();
        p_addr = int'(wr_addr);
        p_data = wr_data;
        p_n    = 1 << wr_size;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mm[i] = 8'hFF;
            m_left = 0; m_op = 0; m_snb = 0; m_pend = 0;
            m_pg = 0; m_ser = 0; m_mer = 0;
            e_al = 0; e_sz = 0; e_sq = 0;
        end else begin
            if (reg_we && reg_addr) begin
                if (reg_wdata[1]) e_al = 0;
                if (reg_wdata[2]) e_sz = 0;
                if (reg_wdata[3]) e_sq = 0;
            end
            wok = 0;
            if (m_left == 0 && wr_valid) begin
                nb = 1 << wr_size;
                fa = ((int'(wr_addr) % 16) + nb) > 16;
                fs = (wr_size != par_cfg);
                fq = !m_pg;
                if (fa) e_al = 1;
                if (fs) e_sz = 1;
                if (fq) e_sq = 1;
                wok = !(fa || fs || fq);
            end
            if (m_left != 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    apply_op(m_op);
                    if (m_op != 3 && m_pend) begin
                        m_pend = 0; m_op = 3; m_left = PROG;
                    end
                end
            end else if (reg_we && !reg_addr) begin
                m_pg  = reg_wdata[0];
                m_ser = reg_wdata[1];
                m_mer = reg_wdata[2];
                m_snb = int'(reg_wdata[6:4]);
                if (reg_wdata[8] && (m_mer != m_ser)) begin
                    m_op = m_mer ? 1 : 2;
                    m_left = ERASE;
                    if (wok) begin m_pend = 1; load_prog(); end
                end else if (wok) begin
                    m_op = 3; m_left = PROG; load_prog();
                end
            end else if (wok) begin
                m_op = 3; m_left = PROG; load_prog();
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    logic [63:0] exp_dw;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({phase, " busy"}, 64'(busy_o), 64'(m_left != 0));
            for (int k = 0; k < 8; k++) exp_dw[8*k +: 8] = mm[int'(rd_addr)*8 + k];
            check({phase, " array"}, rd_data, exp_dw);
            if (!reg_we && reg_addr)
                check({phase, " status"}, 64'(reg_rdata), {60'd0, e_sq, e_sz, e_al, m_left != 0});
        end
        #1;
        scan_ptr = scan_ptr + 4'd1;
        rd_addr  = scan_en ? scan_ptr : dir_addr;
    end

    // ---------------- stimulus helpers ----------------
    task automatic reg_wr(input logic a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #2;
        reg_we = 1'b0; reg_addr = 1'b1; reg_wdata = '0;
    endtask

    task automatic flash_wr(input logic [6:0] a, input logic [63:0] d, input logic [1:0] s);
        wr_addr = a; wr_data = d; wr_size = s; wr_valid = 1'b1;
        @(posedge clk); #2;
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o && n < 1000) begin
            @(posedge clk); #2;
            n++;
        end
    endtask

    task automatic read_dw(input int idx, output logic [63:0] v);
        dir_addr = 4'(idx);
        scan_en  = 1'b0;
        @(negedge clk); #2;
        v = rd_data;
        scan_en = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        int n;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state
        phase = "R1";
        check("R1 status", 64'(reg_rdata[3:0]), 64'd0);
        reg_addr = 1'b0; #1;
        check("R1 control", 64'(reg_rdata), 64'd0);
        reg_addr = 1'b1;
        read_dw(0, v); check("R1 erased dw0", v, '1);

        // R5: program and AND semantics
        phase = "R5";
        reg_wr(1'b0, 32'h1);
        flash_wr(7'd0, 64'h0123456789ABCDEF, 2'd3);
        wait_idle(n); check("R5 program busy cycles", 64'(n), 64'(PROG));
        read_dw(0, v); check("R5 stored", v, 64'h0123456789ABCDEF);
        flash_wr(7'd0, 64'hFFFF0000FFFF0000, 2'd3);
        wait_idle(n);
        read_dw(0, v); check("R5 AND result", v, 64'h0123000089AB0000);

        // R6 / R12: size mismatch dropped
        phase = "R6";
        flash_wr(7'd8, 64'h0, 2'd2);
        check("R12 no busy after drop", 64'(busy_o), 64'd0);
        check("R6 size flag", 64'(reg_rdata[3:0]), 64'h4);
        read_dw(1, v); check("R12 array unchanged", v, '1);

        // R9: sticky, write-one-to-clear
        phase = "R9";
        reg_wr(1'b1, 32'h0);
        check("R9 zero write keeps flag", 64'(reg_rdata[3:0]), 64'h4);
        reg_wr(1'b1, 32'h4);
        check("R9 one clears flag", 64'(reg_rdata[3:0]), 64'h0);

        // R7: row crossing
        phase = "R7";
        par_cfg = 2'd2;
        flash_wr(7'd14, 64'h0, 2'd2);
        check("R7 align flag", 64'(reg_rdata[3:0]), 64'h2);
        read_dw(1, v); check("R7 array unchanged", v, '1);
        reg_wr(1'b1, 32'h2);
        flash_wr(7'd12, 64'h1122334455667788, 2'd2);
        wait_idle(n);
        read_dw(1, v); check("R7 in-row word", v, 64'h55667788FFFFFFFF);

        // R8: sequence error
        phase = "R8";
        par_cfg = 2'd3;
        reg_wr(1'b0, 32'h0);
        flash_wr(7'd16, 64'h0, 2'd3);
        check("R8 seq flag", 64'(reg_rdata[3:0]), 64'h8);
        read_dw(2, v); check("R8 array unchanged", v, '1);
        reg_wr(1'b1, 32'h8);

        // R3 / R10: sector erase, ignored traffic while busy
        phase = "R3";
        reg_wr(1'b0, 32'h1);
        flash_wr(7'd16, 64'hA5A5A5A55A5A5A5A, 2'd3);
        wait_idle(n);
        reg_wr(1'b0, 32'h103);
        check("R3 erase busy", 64'(busy_o), 64'd1);
        phase = "R10";
        flash_wr(7'd24, 64'h0, 2'd3);
        reg_wr(1'b0, 32'h104);
        wait_idle(n);
        check("R10 no flag from busy write", 64'(reg_rdata[3:0]), 64'h0);
        reg_addr = 1'b0; #1;
        check("R10 control unchanged", 64'(reg_rdata), 64'h3);
        reg_addr = 1'b1;
        read_dw(3, v); check("R10 busy write ignored", v, '1);
        phase = "R3";
        read_dw(0, v); check("R3 sector 0 erased", v, '1);
        read_dw(2, v); check("R3 sector 1 kept", v, 64'hA5A5A5A55A5A5A5A);

        // R4: conflicting erase bits
        phase = "R4";
        reg_wr(1'b0, 32'h117);
        check("R4 no busy", 64'(busy_o), 64'd0);
        read_dw(2, v); check("R4 array unchanged", v, 64'hA5A5A5A55A5A5A5A);

        // R11: erase before program
        phase = "R11";
        reg_wr(1'b0, 32'h1);
        wr_addr = 7'd16; wr_data = 64'h0F0F0F0FF0F0F0F0; wr_size = 2'd3; wr_valid = 1'b1;
        reg_addr = 1'b0; reg_wdata = 32'h113; reg_we = 1'b1;
        @(posedge clk); #2;
        wr_valid = 1'b0; reg_we = 1'b0; reg_addr = 1'b1; reg_wdata = '0;
        wait_idle(n); check("R11 busy cycles", 64'(n), 64'(ERASE + PROG));
        read_dw(2, v); check("R11 erase then program", v, 64'h0F0F0F0FF0F0F0F0);

        // R2: mass erase
        phase = "R2";
        reg_wr(1'b0, 32'h104);
        wait_idle(n); check("R2 busy cycles", 64'(n), 64'(ERASE));
        read_dw(2, v); check("R2 dw2 erased", v, '1);
        read_dw(1, v); check("R2 dw1 erased", v, '1);

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule